// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between a CPU register port and an embedded flash array and decides when program and erase pulses may reach the cells. Software selects blocks through two erase-select registers and requests a mode through a control register. The request is honoured only when the software enable bit is set in the same write, only one of the two modes is requested, and no error lockout is present.

While a mode is active, the block watches four CPU status inputs: a flash fetch, the start of exception handling, execution of a sleep, and a bus grant to another master. Any of them ends the mode at once and sets a sticky error flag. The flag then holds both modes off until an asynchronous reset or a standby entry. Reset and standby also clear every register, which aborts any operation in progress.

Register map (8-bit, by `wr_addr_i`/`rd_addr_i`): 0 = mode control, 1 = error status, 2 = erase-select for blocks 7..0, 3 = erase-select for blocks 15..8. Reads are combinational. Writes take effect on the clock edge that samples them.

Top module: `flash_guard`

## Requirements
- R1: After `rst_ni` is asserted low, every register reads 0x00 and `prog_active_o`, `erase_active_o` and `blk_erase_en_o` are 0.
- R2: A clock edge with `standby_i` high clears all four registers, including the error flag, and drops both mode outputs. Writes on that edge are ignored.
- R3: A write to address 0 with bit 6 (enable) equal to 0 leaves program and erase mode off, and bits 1 and 0 read back as 0.
- R4: A write to address 0 with bit 6 = 1 and bit 0 = 1 (program) alone raises `prog_active_o` from the next cycle. Address 0 then reads 0x41.
- R5: A write to address 0 that sets both bit 0 and bit 1 enters neither mode, and both bits read back as 0.
- R6: With bit 1 (erase) accepted and at least one erase-select bit set, `erase_active_o` is 1 and `blk_erase_en_o` equals {reg3, reg2}. Bit n of the vector enables block n.
- R7: While both erase-select registers are 0x00, `erase_active_o` and `blk_erase_en_o` stay 0 even though the erase bit is held.
- R8: If `flash_fetch_i`, `exc_start_i`, `sleep_i` or `bus_grant_i` is high on an edge while a mode output is high, the next cycle shows both mode outputs at 0 and bit 7 of address 1 at 1.
- R9: The same four inputs have no effect while neither mode output is high.
- R10: While the error flag is set, writes cannot set bits 0 and 1 of address 0, which read back as 0. Bit 6 stays writable and readable. The flag holds until reset or standby.
- R11: Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby entry, synchronous clear |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | 8 | Read data, combinational |
| flash_fetch_i | input | 1 | CPU is reading the flash array |
| exc_start_i | input | 1 | Non-reset exception handling starts |
| sleep_i | input | 1 | Sleep being executed |
| bus_grant_i | input | 1 | CPU releases the bus |
| prog_active_o | output | 1 | Program mode active |
| erase_active_o | output | 1 | Erase mode active |
| blk_erase_en_o | output | 16 | Per-block erase enable |

## Verification
Every result is due exactly one cycle after the edge that samples its stimulus. This holds for a register write, an unsafe event while active, and a standby pulse. Read data follows the read address with no delay. The bench drives its inputs just after the falling edge, advances a behavioural model on each rising edge, and compares every output and the read data of a rotating read address on the following falling edge. Each check therefore sees the first cycle in which a change is due, and every cycle after it.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 2'd0,
    A_STAT = 2'd1,
    A_SEL0 = 2'd2,
    A_SEL1 = 2'd3
  } reg_addr_e;

  localparam int unsigned B_PROG = 0;
  localparam int unsigned B_ERAS = 1;
  localparam int unsigned B_SWEN = 6;
  localparam int unsigned B_ERRF = 7;
endpackage

// File: rtl/flash_guard_evt.sv
module flash_guard_evt #(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               active_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               abort_o
);
  logic [NUM_EVT-1:0] gated;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_gate
    assign gated[g] = evt_i[g] & active_i;
  end

  assign abort_o = |gated;
endmodule

// File: rtl/flash_guard_sel.sv
module flash_guard_sel
  import flash_guard_pkg::*;
#(
  parameter int unsigned NUM_REGS = 2,
  parameter int unsigned BASE     = 2,
  localparam int unsigned VEC_W   = NUM_REGS * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              rd_hit_o,
  output logic [VEC_W-1:0]  sel_o
);
  logic [REG_W-1:0] sel_q [NUM_REGS];
  logic [NUM_REGS-1:0] rd_hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             sel_q[g] <= '0;
      else if (clr_i)                          sel_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == MY_ADDR) sel_q[g] <= wr_data_i;
    end
    assign sel_o[g*REG_W +: REG_W] = sel_q[g];
    assign rd_hit[g] = (rd_addr_i == MY_ADDR);
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_hit[i]) rd_data_o = sel_q[i];
  end
  assign rd_hit_o = |rd_hit;
endmodule

// File: rtl/flash_guard_ctl.sv
module flash_guard_ctl
  import flash_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              abort_i,
  output logic              swen_o,
  output logic              prog_o,
  output logic              eras_o,
  output logic              err_o
);
  logic swen_q, prog_q, eras_q, err_q;
  logic mode_wr, req_ok;

  assign mode_wr = wr_en_i && (wr_addr_i == A_MODE);
  // request needs enable in the same write, one mode only, no lockout
  assign req_ok  = wr_data_i[B_SWEN] && !(wr_data_i[B_PROG] && wr_data_i[B_ERAS]) && !err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swen_q <= 1'b0; prog_q <= 1'b0; eras_q <= 1'b0; err_q <= 1'b0;
    end else if (clr_i) begin
      swen_q <= 1'b0; prog_q <= 1'b0; eras_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (mode_wr) swen_q <= wr_data_i[B_SWEN];
      if (abort_i) begin
        err_q  <= 1'b1;
        prog_q <= 1'b0;
        eras_q <= 1'b0;
      end else if (mode_wr) begin
        prog_q <= req_ok & wr_data_i[B_PROG];
        eras_q <= req_ok & wr_data_i[B_ERAS];
      end
    end
  end

  assign swen_o = swen_q;
  assign prog_o = prog_q;
  assign eras_o = eras_q;
  assign err_o  = err_q;

  p_swen_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_q) || $rose(eras_q) |-> swen_q);
  p_one_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_q && eras_q));
  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && !clr_i |=> err_q && !prog_q && !eras_q);
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr_i |=> err_q);
  p_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !prog_q && !eras_q);
  p_standby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !swen_q && !prog_q && !eras_q && !err_q);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned NUM_SEL_REGS = 2,
  localparam int unsigned BLK_N = NUM_SEL_REGS * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              flash_fetch_i,
  input  logic              exc_start_i,
  input  logic              sleep_i,
  input  logic              bus_grant_i,
  output logic              prog_active_o,
  output logic              erase_active_o,
  output logic [BLK_N-1:0]  blk_erase_en_o
);
  logic swen, prog, eras, err, abort, any_active, sel_hit;
  logic [BLK_N-1:0] sel_vec;
  logic [REG_W-1:0] sel_rd, ctl_rd;

  flash_guard_ctl u_ctl (
    .clk_i, .rst_ni, .clr_i(standby_i),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .abort_i(abort),
    .swen_o(swen), .prog_o(prog), .eras_o(eras), .err_o(err)
  );

  flash_guard_sel #(.NUM_REGS(NUM_SEL_REGS), .BASE(2)) u_sel (
    .clk_i, .rst_ni, .clr_i(standby_i),
    .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .rd_data_o(sel_rd), .rd_hit_o(sel_hit), .sel_o(sel_vec)
  );

  assign prog_active_o  = prog;
  assign erase_active_o = eras && (|sel_vec);
  assign blk_erase_en_o = erase_active_o ? sel_vec : '0;
  assign any_active     = prog_active_o | erase_active_o;

  flash_guard_evt #(.NUM_EVT(4)) u_evt (
    .active_i(any_active),
    .evt_i({bus_grant_i, sleep_i, exc_start_i, flash_fetch_i}),
    .abort_o(abort)
  );

  always_comb begin
    ctl_rd = '0;
    unique case (rd_addr_i)
      A_MODE: begin
        ctl_rd[B_SWEN] = swen;
        ctl_rd[B_ERAS] = eras;
        ctl_rd[B_PROG] = prog;
      end
      A_STAT:  ctl_rd[B_ERRF] = err;
      default: ctl_rd = '0;
    endcase
  end
  assign rd_data_o = sel_hit ? sel_rd : ctl_rd;

  p_blk_subset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_erase_en_o & ~sel_vec) == '0);
  p_blk_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_vec == '0) |-> !erase_active_o);
  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_active && !err |=> !err);
endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic fetch = 1'b0, exc = 1'b0, slp = 1'b0, grant = 1'b0;
  logic prog_act, eras_act;
  logic [15:0] blk_en;

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // reference state
  bit m_swen, m_prog, m_eras, m_err;
  bit [7:0] m_sel0, m_sel1;

  always #2 clk = ~clk;

  flash_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .flash_fetch_i(fetch), .exc_start_i(exc), .sleep_i(slp), .bus_grant_i(grant),
    .prog_active_o(prog_act), .erase_active_o(eras_act), .blk_erase_en_o(blk_en)
  );

  function automatic bit m_eact();
    return m_eras && ({m_sel1, m_sel0} != 16'h0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || standby) begin
      m_swen = 0; m_prog = 0; m_eras = 0; m_err = 0; m_sel0 = 0; m_sel1 = 0;
    end else begin
      bit ev, act;
      ev  = fetch | exc | slp | grant;
      act = m_prog | m_eact();
      if (wr_en && wr_addr == 2'd0) m_swen = wr_data[6];
      if (act && ev) begin
        m_err = 1; m_prog = 0; m_eras = 0;
      end else if (wr_en && wr_addr == 2'd0) begin
        if (!m_err && wr_data[6] && !(wr_data[0] && wr_data[1])) begin
          m_prog = wr_data[0]; m_eras = wr_data[1];
        end else begin
          m_prog = 0; m_eras = 0;
        end
      end
      if (wr_en && wr_addr == 2'd2) m_sel0 = wr_data;
      if (wr_en && wr_addr == 2'd3) m_sel1 = wr_data;
    end
  end

  function automatic bit [7:0] m_read(input bit [1:0] a);
    case (a)
      2'd0: return {1'b0, m_swen, 4'b0, m_eras, m_prog};
      2'd1: return {m_err, 7'b0};
      2'd2: return m_sel0;
      default: return m_sel1;
    endcase
  endfunction

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("prog_active", {15'b0, prog_act}, {15'b0, m_prog});
    chk("erase_active", {15'b0, eras_act}, {15'b0, m_eact()});
    chk("blk_erase_en", blk_en, m_eact() ? {m_sel1, m_sel0} : 16'h0);
    chk("rd_data", {8'b0, rd_data}, {8'b0, m_read(rd_addr)});
    #1 rd_addr <= rd_addr + 2'd1;
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
    step(4);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: fetch = 1;
      1: exc = 1;
      2: slp = 1;
      default: grant = 1;
    endcase
    step();
    fetch = 0; exc = 0; slp = 0; grant = 0;
    step(4);
  endtask

  task automatic go_standby();
    standby = 1; wr_en = 1; wr_addr = 2'd2; wr_data = 8'hFF;
    step();
    standby = 0; wr_en = 0;
    step(4);
  endtask

  initial begin
    cur_req = "R1"; step(3); rst_n = 1; step(5);
    cur_req = "R9";  for (int i = 0; i < 4; i++) pulse(i);
    cur_req = "R3";  wr(0, 8'h01); wr(0, 8'h02);
    cur_req = "R4";  wr(0, 8'h41);
    cur_req = "R3";  wr(0, 8'h00);
    cur_req = "R5";  wr(0, 8'h43);
    cur_req = "R7";  wr(0, 8'h42); pulse(2);
    cur_req = "R6";  wr(2, 8'h05); wr(3, 8'h80); wr(3, 8'h00);
    cur_req = "R8";  pulse(2);
    cur_req = "R10"; wr(0, 8'h41); wr(0, 8'h42); wr(0, 8'h00); wr(0, 8'h40);
    cur_req = "R11"; wr(1, 8'h00);
    cur_req = "R2";  go_standby();
    for (int i = 0; i < 4; i++) begin
      cur_req = "R8"; wr(0, 8'h41); pulse(i);
      cur_req = "R2"; go_standby();
      cur_req = "R8"; wr(3, 8'h10); wr(0, 8'h42); pulse(i);
      cur_req = "R2"; go_standby();
    end
    cur_req = "R11"; wr(1, 8'hFF);
    cur_req = "R1";  wr(2, 8'hAA); wr(0, 8'h42);
    rst_n = 0; step(2); rst_n = 1; step(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule